// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Unit

This block is the delivery side of a multiprocessor interrupt controller. For every processor it keeps two bitmaps over the interrupt sources. The pending-delivery set holds sources offered to that processor and not yet taken. The in-service set holds sources the processor has accepted and not yet retired. A 4-bit task priority threshold gates each processor, and each processor has one interrupt request line. A source router upstream offers raise requests, one per cycle. Each request names a processor, a source index, a priority, a vector and whether the source is edge or level triggered. The router also reports when a level source drops, which makes that source stale.

Software talks to the block over a 32-bit register bus with a processor select. Writes take effect in one cycle, and read data is registered and returned one cycle later. Reading the acknowledge slot takes the best pending source for that processor. The read returns the source's vector, or a spurious vector if there is nothing valid to deliver. Writing the completion slot retires the best in-service source. The request line is driven again if a pending source now outranks what is left in service.

Each processor's request line is a two-state machine, LINE_LOW and LINE_HIGH. It goes from LINE_LOW to LINE_HIGH when an accepted raise is visible or a completion write uncovers a pending source. It goes from LINE_HIGH to LINE_LOW on an acknowledge read, unless a visible raise arrives in the same cycle. The bus read path is a second two-state machine. It moves to BUS_DATA in any cycle with a read, which marks read data valid next cycle, and otherwise returns to BUS_IDLE.

Top module: `irq_ack_unit`

## Requirements
- R1: After reset every processor's threshold reads 0xF, every request line is low, both sets are empty and read-valid is low.
- R2: A raise whose priority is less than or equal to the target processor's threshold is discarded: the line does not change and a later acknowledge returns the spurious vector.
- R3: A raise for a source already in that processor's pending set is dropped as missed. Otherwise the source becomes active and joins the pending set.
- R4: An accepted raise drives the line high only if its priority is at least the current best pending priority (or nothing is pending). It must also be strictly above the best in-service priority, unless nothing is in service.
- R5: The best member of a set is the one with the highest priority, and among equal priorities the lowest source index.
- R6: A read of the acknowledge slot (address 0xA0) drops the line. With an empty pending set it returns the spurious vector 0xFF in bits 7:0, with the upper bits zero.
- R7: If the best pending source is stale at acknowledge, it is cleared from active and the spurious vector is returned. Stale means its level source has dropped, or its priority is no longer above the threshold. The source leaves the pending set either way.
- R8: If the best pending source is valid at acknowledge, it moves from the pending set to the in-service set and its 8-bit vector is returned.
- R9: Acknowledging an edge-triggered source clears its active flag and pulses pend_clr_valid, with that source's index, together with the read data. A level source gives no pulse.
- R10: A write to the completion slot (address 0xB0) removes the best in-service source. The line is driven high if a pending source exists and either nothing is left in service or its priority is strictly above the remaining best in-service priority.
- R11: Address 0x80 holds the threshold, and only write bits 3:0 are kept. Address 0x90 reads back the selected processor index, address 0xB0 reads 0, and any other aligned address reads all ones.
- R12: An access whose address bits 3:0 are nonzero changes nothing (no threshold update, no acknowledge, no completion), and such a read returns all ones.
- R13: bus_rvalid is high exactly in the cycle after a cycle with bus_rd high, and bus_rdata holds the value for that read.
- R14: Processors are independent: a raise or register access for one processor leaves the other's line, sets and threshold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_valid | input | 1 | Raise request strobe from the source router |
| raise_cpu | input | 1 | Target processor of the raise |
| raise_src | input | 6 | Source index of the raise |
| raise_prio | input | 4 | Source priority |
| raise_vec | input | 8 | Source vector |
| raise_edge | input | 1 | 1 = edge-triggered source, 0 = level |
| drop_valid | input | 1 | Level source has deasserted |
| drop_src | input | 6 | Index of the dropped source |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_cpu | input | 1 | Processor whose register view is accessed |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| irq | output | 2 | Interrupt request line per processor |
| pend_clr_valid | output | 1 | Edge source acknowledged: router clears its pending flag |
| pend_clr_src | output | 6 | Index for pend_clr_valid |

## Verification
The properties assume the bus never reads and writes in the same cycle. They also assume raise_cpu and bus_cpu name existing processors, and the line-drop property only applies in cycles with no raise to the same processor. The bench drives at most one operation per cycle, so it stays inside these limits, and it compares every acknowledge, register read and request line against a set-level model. The model is built from the requirements. The stimulus sweeps every threshold against every priority and every pair of priorities across two sources with mixed triggering. It also runs directed sequences for ties, missed raises, stale acknowledges, nested service and misaligned accesses.

// File: rtl/irqack_pkg.sv
package irqack_pkg;

    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_DATA = 1'b1
    } bus_state_e;

    // register slots, decoded from address bits above the low nibble
    localparam logic [7:0] SLOT_TPR = 8'h08;
    localparam logic [7:0] SLOT_WHO = 8'h09;
    localparam logic [7:0] SLOT_ACK = 8'h0A;
    localparam logic [7:0] SLOT_EOI = 8'h0B;

endpackage

// File: rtl/irqack_pick.sv
module irqack_pick #(
    parameter int N  = 64,
    parameter int PW = 4,
    parameter int IW = 6
) (
    input  logic [N-1:0]         members,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 hit,
    output logic [IW-1:0]        idx,
    output logic [PW-1:0]        best
);

    // highest priority wins; strict compare keeps the lowest index on ties
    always_comb begin
        hit  = 1'b0;
        idx  = '1;
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (members[i] && (!hit || (prio[i] > best))) begin
                hit  = 1'b1;
                idx  = IW'(i);
                best = prio[i];
            end
        end
    end

endmodule

// File: rtl/irqack_regif.sv
module irqack_regif
    import irqack_pkg::*;
#(
    parameter int NCPU   = 2,
    parameter int CW     = 1,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int PW     = 4,
    parameter int VW     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [CW-1:0]            bus_cpu,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic [NCPU-1:0][PW-1:0]  tpr_all,
    input  logic [VW-1:0]            ack_vec,
    output logic [NCPU-1:0]          ack_stb,
    output logic [NCPU-1:0]          eoi_stb,
    output logic [NCPU-1:0]          tpr_stb,
    output logic [PW-1:0]            tpr_data,
    output logic                     ack_go,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     bus_rvalid
);

    localparam int SW = ADDR_W - 4;

    logic          aligned;
    logic [SW-1:0] slot;
    logic [DATA_W-1:0] rd_mux;
    logic          unused_wdata;
    bus_state_e    state_q, state_n;

    assign aligned      = (bus_addr[3:0] == 4'h0);
    assign slot         = bus_addr[ADDR_W-1:4];
    assign tpr_data     = bus_wdata[PW-1:0];
    assign unused_wdata = ^bus_wdata[DATA_W-1:PW];
    assign ack_go       = bus_rd && aligned && (slot == SW'(SLOT_ACK));

    // per-processor single-cycle strobes
    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            ack_stb[c] = ack_go && (bus_cpu == CW'(c));
            eoi_stb[c] = bus_wr && aligned && (slot == SW'(SLOT_EOI)) && (bus_cpu == CW'(c));
            tpr_stb[c] = bus_wr && aligned && (slot == SW'(SLOT_TPR)) && (bus_cpu == CW'(c));
        end
    end

    always_comb begin
        rd_mux = '1;
        if (aligned) begin
            case (slot)
                SW'(SLOT_TPR): rd_mux = DATA_W'(tpr_all[bus_cpu]);
                SW'(SLOT_WHO): rd_mux = DATA_W'(bus_cpu);
                SW'(SLOT_ACK): rd_mux = DATA_W'(ack_vec);
                SW'(SLOT_EOI): rd_mux = '0;
                default:       rd_mux = '1;
            endcase
        end
    end

    // read-return state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            BUS_IDLE: state_n = bus_rd ? BUS_DATA : BUS_IDLE;
            BUS_DATA: state_n = bus_rd ? BUS_DATA : BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign bus_rvalid = (state_q == BUS_DATA);

endmodule

// File: rtl/irqack_cpu.sv
module irqack_cpu
    import irqack_pkg::*;
#(
    parameter int N  = 64,
    parameter int PW = 4,
    parameter int IW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 raise_hit,
    input  logic [IW-1:0]        raise_src,
    input  logic [PW-1:0]        raise_prio,
    input  logic [N-1:0][PW-1:0] src_prio,
    input  logic [N-1:0]         src_act,
    input  logic                 ack_stb,
    input  logic                 eoi_stb,
    input  logic                 tpr_stb,
    input  logic [PW-1:0]        tpr_data,
    output logic                 irq,
    output logic [PW-1:0]        tpr_q,
    output logic                 accept,
    output logic                 top_hit,
    output logic [IW-1:0]        top_idx,
    output logic                 top_live
);

    logic [N-1:0]  raised_q, raised_n;
    logic [N-1:0]  inserv_q, inserv_n;
    logic [N-1:0]  sv_bit, rest_set;
    logic          rz_hit, sv_hit, rs_hit;
    logic [IW-1:0] rz_idx, sv_idx, rs_idx;
    logic [PW-1:0] rz_prio, sv_prio, rs_prio;
    logic          show_raise, show_eoi;
    line_state_e   line_q, line_n;

    irqack_pick #(.N(N), .PW(PW), .IW(IW)) u_pick_raised (
        .members(raised_q), .prio(src_prio), .hit(rz_hit), .idx(rz_idx), .best(rz_prio));

    irqack_pick #(.N(N), .PW(PW), .IW(IW)) u_pick_inserv (
        .members(inserv_q), .prio(src_prio), .hit(sv_hit), .idx(sv_idx), .best(sv_prio));

    // in-service set as it would stand after a completion
    irqack_pick #(.N(N), .PW(PW), .IW(IW)) u_pick_rest (
        .members(rest_set), .prio(src_prio), .hit(rs_hit), .idx(rs_idx), .best(rs_prio));

    always_comb begin
        sv_bit = '0;
        if (sv_hit) sv_bit[sv_idx] = 1'b1;
        rest_set = inserv_q & ~sv_bit;
    end

    always_comb begin
        accept     = raise_hit && (raise_prio > tpr_q) && !raised_q[raise_src];
        show_raise = accept
                  && (!rz_hit || (raise_prio >= rz_prio))
                  && (!sv_hit || (raise_prio > sv_prio));
        show_eoi   = eoi_stb && rz_hit && (!rs_hit || (rz_prio > rs_prio));
        top_live   = src_act[rz_idx] && (src_prio[rz_idx] > tpr_q);
        top_hit    = rz_hit;
        top_idx    = rz_idx;
    end

    always_comb begin
        raised_n = raised_q;
        inserv_n = inserv_q;
        if (ack_stb && rz_hit) begin
            raised_n[rz_idx] = 1'b0;
            if (top_live) inserv_n[rz_idx] = 1'b1;
        end
        if (eoi_stb && sv_hit) inserv_n[sv_idx] = 1'b0;
        if (accept) raised_n[raise_src] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raised_q <= '0;
            inserv_q <= '0;
            tpr_q    <= '1;
        end else begin
            raised_q <= raised_n;
            inserv_q <= inserv_n;
            if (tpr_stb) tpr_q <= tpr_data;
        end
    end

    // request line state register
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= LINE_LOW;
        else        line_q <= line_n;
    end

    always_comb begin
        line_n = line_q;
        unique case (line_q)
            LINE_LOW:  if (show_raise || show_eoi) line_n = LINE_HIGH;
            LINE_HIGH: if (ack_stb && !show_raise) line_n = LINE_LOW;
        endcase
    end

    // output process
    always_comb begin
        irq = (line_q == LINE_HIGH);
    end

endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irqack_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CPU  = 2,
    parameter int PRIO_W   = 4,
    parameter int VEC_W    = 8,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter logic [VEC_W-1:0] SPUR_VEC = '1,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_valid,
    input  logic [CPU_W-1:0]  raise_cpu,
    input  logic [SRC_W-1:0]  raise_src,
    input  logic [PRIO_W-1:0] raise_prio,
    input  logic [VEC_W-1:0]  raise_vec,
    input  logic              raise_edge,
    input  logic              drop_valid,
    input  logic [SRC_W-1:0]  drop_src,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [CPU_W-1:0]  bus_cpu,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [NUM_CPU-1:0] irq,
    output logic              pend_clr_valid,
    output logic [SRC_W-1:0]  pend_clr_src
);

    // source table, captured on every accepted raise
    logic [NUM_SRC-1:0][PRIO_W-1:0] tbl_prio;
    logic [NUM_SRC-1:0][VEC_W-1:0]  tbl_vec;
    logic [NUM_SRC-1:0]             tbl_edge;
    logic [NUM_SRC-1:0]             act_q, act_n;

    logic [NUM_CPU-1:0]             cpu_acc, cpu_hit, cpu_live;
    logic [NUM_CPU-1:0][SRC_W-1:0]  cpu_idx;
    logic [NUM_CPU-1:0][PRIO_W-1:0] cpu_tpr;
    logic [NUM_CPU-1:0]             ack_stb, eoi_stb, tpr_stb;
    logic [PRIO_W-1:0]              tpr_data;
    logic                           ack_go, any_accept;
    logic                           sel_hit, sel_live;
    logic [SRC_W-1:0]               sel_idx;
    logic [VEC_W-1:0]               ack_vec;

    irqack_regif #(
        .NCPU(NUM_CPU), .CW(CPU_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .PW(PRIO_W), .VW(VEC_W)
    ) u_regif (
        .clk(clk), .rst_n(rst_n),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_cpu(bus_cpu),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .tpr_all(cpu_tpr), .ack_vec(ack_vec),
        .ack_stb(ack_stb), .eoi_stb(eoi_stb), .tpr_stb(tpr_stb),
        .tpr_data(tpr_data), .ack_go(ack_go),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        irqack_cpu #(.N(NUM_SRC), .PW(PRIO_W), .IW(SRC_W)) u_cpu (
            .clk(clk), .rst_n(rst_n),
            .raise_hit(raise_valid && (raise_cpu == CPU_W'(c))),
            .raise_src(raise_src), .raise_prio(raise_prio),
            .src_prio(tbl_prio), .src_act(act_q),
            .ack_stb(ack_stb[c]), .eoi_stb(eoi_stb[c]), .tpr_stb(tpr_stb[c]),
            .tpr_data(tpr_data),
            .irq(irq[c]), .tpr_q(cpu_tpr[c]), .accept(cpu_acc[c]),
            .top_hit(cpu_hit[c]), .top_idx(cpu_idx[c]), .top_live(cpu_live[c])
        );
    end

    assign any_accept = |cpu_acc;
    assign sel_hit    = cpu_hit[bus_cpu];
    assign sel_live   = cpu_live[bus_cpu];
    assign sel_idx    = cpu_idx[bus_cpu];
    assign ack_vec    = (sel_hit && sel_live) ? tbl_vec[sel_idx] : SPUR_VEC;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_prio <= '0;
            tbl_vec  <= '0;
            tbl_edge <= '0;
        end else if (any_accept) begin
            tbl_prio[raise_src] <= raise_prio;
            tbl_vec[raise_src]  <= raise_vec;
            tbl_edge[raise_src] <= raise_edge;
        end
    end

    // activity: drop and acknowledge clear, an accepted raise sets last
    always_comb begin
        act_n = act_q;
        if (drop_valid) act_n[drop_src] = 1'b0;
        if (ack_go && sel_hit && (!sel_live || tbl_edge[sel_idx])) act_n[sel_idx] = 1'b0;
        if (any_accept) act_n[raise_src] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q          <= '0;
            pend_clr_valid <= 1'b0;
            pend_clr_src   <= '0;
        end else begin
            act_q          <= act_n;
            pend_clr_valid <= ack_go && sel_hit && tbl_edge[sel_idx];
            pend_clr_src   <= sel_idx;
        end
    end

endmodule

// File: rtl/irq_ack_unit_chk.sv
module irq_ack_unit_chk #(
    parameter int NUM_CPU = 2,
    parameter int CPU_W   = 1,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               raise_valid,
    input logic [CPU_W-1:0]   raise_cpu,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [CPU_W-1:0]   bus_cpu,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               bus_rvalid,
    input logic [NUM_CPU-1:0] irq,
    input logic               pend_clr_valid
);

    localparam int SW = ADDR_W - 4;

    logic          al;
    logic [SW-1:0] sl;
    assign al = (bus_addr[3:0] == 4'h0);
    assign sl = bus_addr[ADDR_W-1:4];

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_line
        // R6
        ack_drops_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && al && (sl == SW'(8'h0A)) && (bus_cpu == CPU_W'(c))
             && !(raise_valid && (raise_cpu == CPU_W'(c))))
            |=> !irq[c]);
        // R4
        line_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq[c] && !(raise_valid && (raise_cpu == CPU_W'(c)))
             && !(bus_wr && al && (sl == SW'(8'h0B)) && (bus_cpu == CPU_W'(c))))
            |=> !irq[c]);
    end

    // R12
    misaligned_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !al) |=> (bus_rdata == '1));

    // R11
    eoi_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && al && (sl == SW'(8'h0B))) |=> (bus_rdata == '0));

    // R11
    who_reads_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && al && (sl == SW'(8'h09))) |=> (bus_rdata == DATA_W'($past(bus_cpu))));

    // R13
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R13
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R9
    pend_clr_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr_valid |-> bus_rvalid);

endmodule

bind irq_ack_unit irq_ack_unit_chk #(
    .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .raise_valid(raise_valid), .raise_cpu(raise_cpu),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq),
    .pend_clr_valid(pend_clr_valid)
);

// File: tb/sim_irq_ack_unit.sv
`timescale 1ns/1ps
module sim_irq_ack_unit;

    localparam int NS = 64;
    localparam int NC = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, raise_valid, raise_edge, drop_valid, bus_rd, bus_wr;
    logic [0:0]  raise_cpu, bus_cpu;
    logic [5:0]  raise_src, drop_src, pend_clr_src;
    logic [3:0]  raise_prio;
    logic [7:0]  raise_vec;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_rvalid, pend_clr_valid;
    logic [1:0]  irq;

    irq_ack_unit u0 (
        .clk(clk), .rst_n(rst_n), .raise_valid(raise_valid), .raise_cpu(raise_cpu),
        .raise_src(raise_src), .raise_prio(raise_prio), .raise_vec(raise_vec),
        .raise_edge(raise_edge), .drop_valid(drop_valid), .drop_src(drop_src),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .irq(irq), .pend_clr_valid(pend_clr_valid), .pend_clr_src(pend_clr_src)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // set-level model built from the requirements
    bit m_rz [NC][NS];
    bit m_sv [NC][NS];
    int m_pr [NS];
    int m_vc [NS];
    bit m_ed [NS];
    bit m_ac [NS];
    int m_tpr[NC];
    bit m_irq[NC];

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // R5: highest priority, lowest index on ties
    function automatic int top(int c, bit inserv);
        int best = -1;
        int bp = -1;
        for (int i = 0; i < NS; i++) begin
            if ((inserv ? m_sv[c][i] : m_rz[c][i]) && (m_pr[i] > bp)) begin
                best = i;
                bp = m_pr[i];
            end
        end
        return best;
    endfunction

    task automatic idle_in();
        raise_valid = 0; raise_cpu = 0; raise_src = 0; raise_prio = 0;
        raise_vec = 0; raise_edge = 0; drop_valid = 0; drop_src = 0;
        bus_rd = 0; bus_wr = 0; bus_cpu = 0; bus_addr = 0; bus_wdata = 0;
    endtask

    task automatic chk_lines(string tag);
        for (int c = 0; c < NC; c++) chk(tag, 32'(irq[c]), 32'(m_irq[c]));
    endtask

    task automatic raise(int c, int s, int p, int v, bit e, string tag);
        int rt = top(c, 0);
        int st = top(c, 1);
        if ((p > m_tpr[c]) && !m_rz[c][s]) begin
            if ((rt < 0 || p >= m_pr[rt]) && (st < 0 || p > m_pr[st])) m_irq[c] = 1;
            m_rz[c][s] = 1; m_ac[s] = 1; m_pr[s] = p; m_vc[s] = v; m_ed[s] = e;
        end
        raise_valid = 1; raise_cpu = 1'(c); raise_src = 6'(s);
        raise_prio = 4'(p); raise_vec = 8'(v); raise_edge = e;
        @(negedge clk);
        raise_valid = 0;
        chk_lines(tag);
    endtask

    task automatic drop(int s);
        m_ac[s] = 0;
        drop_valid = 1; drop_src = 6'(s);
        @(negedge clk);
        drop_valid = 0;
    endtask

    task automatic ack(int c, string tag);
        int t = top(c, 0);
        int exp = 'hFF;
        bit pend = 0;
        if (t >= 0) begin
            bit live = m_ac[t] && (m_pr[t] > m_tpr[c]);
            if (live) begin m_sv[c][t] = 1; exp = m_vc[t]; end
            if (!live || m_ed[t]) m_ac[t] = 0;
            pend = m_ed[t];
            m_rz[c][t] = 0;
        end
        m_irq[c] = 0;
        bus_rd = 1; bus_cpu = 1'(c); bus_addr = 12'h0A0;
        @(negedge clk);
        bus_rd = 0;
        chk({tag, " ack data"}, bus_rdata, 32'(exp));
        chk({tag, " R13 rvalid"}, 32'(bus_rvalid), 32'd1);
        chk({tag, " R9 pend strobe"}, 32'(pend_clr_valid), 32'(pend));
        if (pend) chk({tag, " R9 pend index"}, 32'(pend_clr_src), 32'(t));
        chk_lines(tag);
    endtask

    task automatic eoi(int c, string tag);
        int s = top(c, 1);
        int r, rest;
        if (s >= 0) m_sv[c][s] = 0;
        r = top(c, 0);
        rest = top(c, 1);
        if (r >= 0 && (rest < 0 || m_pr[r] > m_pr[rest])) m_irq[c] = 1;
        bus_wr = 1; bus_cpu = 1'(c); bus_addr = 12'h0B0; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 0;
        chk({tag, " R13 no rvalid"}, 32'(bus_rvalid), 32'd0);
        chk_lines(tag);
    endtask

    task automatic wr(int c, int addr, int data);
        bus_wr = 1; bus_cpu = 1'(c); bus_addr = 12'(addr); bus_wdata = 32'(data);
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic wtpr(int c, int v);
        m_tpr[c] = v & 15;
        wr(c, 'h80, v);
    endtask

    task automatic rd(int c, int addr, logic [31:0] exp, string tag);
        bus_rd = 1; bus_cpu = 1'(c); bus_addr = 12'(addr);
        @(negedge clk);
        bus_rd = 0;
        chk(tag, bus_rdata, exp);
        chk({tag, " R13 rvalid"}, 32'(bus_rvalid), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle_in();
        for (int c = 0; c < NC; c++) begin
            m_tpr[c] = 15; m_irq[c] = 0;
            for (int i = 0; i < NS; i++) begin m_rz[c][i] = 0; m_sv[c][i] = 0; end
        end
        for (int i = 0; i < NS; i++) begin m_pr[i] = 0; m_vc[i] = 0; m_ed[i] = 0; m_ac[i] = 0; end
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk_lines("R1 line after reset");
        chk("R1 rvalid after reset", 32'(bus_rvalid), 32'd0);
        rd(0, 'h80, 32'hF, "R1 cpu0 threshold");
        rd(1, 'h80, 32'hF, "R1 cpu1 threshold");
        ack(0, "R6 empty acknowledge");

        // R11 register map
        rd(0, 'h90, 32'd0, "R11 index cpu0");
        rd(1, 'h90, 32'd1, "R11 index cpu1");
        rd(0, 'hB0, 32'd0, "R11 completion reads zero");
        rd(0, 'h00, 32'hFFFF_FFFF, "R11 unmapped aligned");
        rd(1, 'hC0, 32'hFFFF_FFFF, "R11 unmapped aligned hi");
        wtpr(0, 'h5A);
        rd(0, 'h80, 32'hA, "R11 threshold keeps low bits");

        // R2 threshold against priority, every pair
        for (int tp = 0; tp < 16; tp++) begin
            for (int p = 0; p < 16; p++) begin
                wtpr(0, tp);
                raise(0, (tp * 16 + p) % NS, p, tp * 16 + p, 1'b1, "R2 sweep line");
                ack(0, "R2 sweep");
                eoi(0, "R2 sweep");
            end
        end
        wtpr(0, 0);

        // R5 ties and ordering, R4 equal priority keeps line high
        raise(0, 40, 6, 'h40, 1'b1, "R4 first raise");
        raise(0, 5, 6, 'h05, 1'b1, "R4 equal priority");
        raise(0, 20, 6, 'h20, 1'b1, "R4 equal priority 2");
        raise(0, 50, 9, 'h50, 1'b1, "R4 higher priority");
        ack(0, "R5 highest first");
        chk("R5 vector 50", bus_rdata, 32'h50);
        ack(0, "R5 tie low index");
        chk("R5 vector 5", bus_rdata, 32'h05);
        ack(0, "R5 tie next");
        ack(0, "R5 tie last");
        chk("R5 vector 40", bus_rdata, 32'h40);
        repeat (4) eoi(0, "R10 drain");

        // R3 missed raise
        raise(0, 7, 3, 'h77, 1'b1, "R3 first");
        raise(0, 7, 3, 'h78, 1'b1, "R3 duplicate");
        ack(0, "R3 one delivery");
        chk("R3 vector kept from first", bus_rdata, 32'h77);
        ack(0, "R3 duplicate dropped");
        chk("R3 spurious", bus_rdata, 32'hFF);
        eoi(0, "R3 retire");

        // R7 stale by threshold and by level drop; R8/R9 live level source
        raise(0, 9, 5, 'h99, 1'b1, "R7 raise");
        wtpr(0, 7);
        ack(0, "R7 stale threshold");
        chk("R7 threshold spurious", bus_rdata, 32'hFF);
        wtpr(0, 0);
        raise(0, 10, 4, 'hA1, 1'b0, "R7 level raise");
        drop(10);
        ack(0, "R7 stale level");
        chk("R7 level spurious", bus_rdata, 32'hFF);
        ack(0, "R7 removed from pending");
        raise(0, 11, 4, 'hB1, 1'b0, "R8 level raise");
        ack(0, "R8 level live");
        chk("R8 level vector", bus_rdata, 32'hB1);
        eoi(0, "R8 retire");

        // R10 nesting and completion re-assert
        raise(0, 12, 8, 'hC8, 1'b1, "R10 raise 8");
        ack(0, "R10 take 8");
        raise(0, 13, 6, 'hD6, 1'b1, "R4 masked by service");
        raise(0, 14, 8, 'hE8, 1'b1, "R4 equal to service");
        eoi(0, "R10 uncover pending");
        ack(0, "R10 take 14");
        raise(0, 15, 10, 'hFA, 1'b1, "R4 above service");
        ack(0, "R8 nested");
        raise(0, 16, 9, 'h19, 1'b1, "R4 below top service");
        eoi(0, "R10 pending beats rest");
        ack(0, "R10 take 16");
        eoi(0, "R10 a");
        eoi(0, "R10 b");
        ack(0, "R10 take 13");
        eoi(0, "R10 c");
        eoi(0, "R10 empty completion");

        // R14 independence
        wtpr(1, 0);
        raise(1, 30, 3, 'h3C, 1'b1, "R14 cpu1 raise");
        raise(0, 31, 2, 'h2D, 1'b0, "R14 cpu0 raise");
        rd(0, 'h80, 32'h0, "R14 cpu0 threshold kept");
        ack(1, "R14 cpu1 ack");
        chk("R14 cpu1 vector", bus_rdata, 32'h3C);

        // R12 misaligned accesses: cpu0 line is high here
        rd(0, 'hA4, 32'hFFFF_FFFF, "R12 misaligned ack read");
        chk_lines("R12 line kept");
        wr(0, 'h88, 3);
        rd(0, 'h80, 32'h0, "R12 misaligned write ignored");
        wr(1, 'hB8, 0);
        chk_lines("R12 misaligned completion");
        ack(0, "R12 ack still pending");
        chk("R12 vector intact", bus_rdata, 32'h2D);
        eoi(0, "R14 retire0");
        eoi(1, "R14 retire1");
        drop(31);

        // R4/R5 pair sweep with mixed triggering
        for (int a = 1; a < 16; a++) begin
            for (int b = 1; b < 16; b++) begin
                raise(0, a, a, a, a[0], "R4 pair first");
                raise(0, 32 + b, b, 128 + b, b[0], "R4 pair second");
                ack(0, "R5 pair ack");
                ack(0, "R5 pair ack2");
                eoi(0, "R10 pair");
                eoi(0, "R10 pair2");
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule